// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register store of a processor that uses overlapping register windows. At any moment it shows 32 architectural registers, each 32 bits wide, numbered by a 5-bit index. The physical array is larger than that. The current window pointer selects which slice of the array is visible. Registers 0 to 7 are globals that every window shares, and global 0 always reads as zero. Registers 8 to 15 are the window's outs, 16 to 23 its locals and 24 to 31 its ins.

The windowed part of the array is a circular buffer of 16 × NWIN registers. Window w's ins are the same storage as window w+1's outs. A save moves the pointer down by one, so the caller's outs become the callee's ins without any copy. A restore moves the pointer up again.

Each cycle the block serves two combinational reads and one write. A mask register has one bit per window. A save or restore that would enter a masked window raises an overflow or underflow trap and leaves the pointer where it is. Spilling windows to memory and the trap handlers themselves are handled elsewhere.

Top module: `wreg_file`

## Requirements
- R1: After reset the pointer is 0, every register reads zero, no trap is raised, and the mask has only bit 1 set (window 1 invalid).
- R2: Address 0 always reads zero, and a write to address 0 has no effect.
- R3: Registers 0–7 are the same storage in every window.
- R4: A write lands at the next clock edge in the register named by its address under the current pointer, and both read ports return stored values independently.
- R5: When a read address equals a write address (not 0) in a cycle with the write enabled, that read returns the incoming write data.
- R6: A save that is not trapped sets the pointer to (pointer − 1) mod NWIN at the next edge. A restore that is not trapped sets it to (pointer + 1) mod NWIN.
- R7: Registers 24–31 of window w are the same storage as registers 8–15 of window (w + 1) mod NWIN.
- R8: Registers 16–23 are private to each window.
- R9: A save whose target window has its mask bit set raises the overflow trap in that cycle, and the pointer does not change.
- R10: A restore whose target window has its mask bit set raises the underflow trap in that cycle, and the pointer does not change.
- R11: With the mask load enabled, the mask takes the load value at the next edge. Trap decisions in the same cycle use the old mask.
- R12: When save and restore are requested together, only the save is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_addr | input | 5 | Read port A architectural address |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 5 | Read port B architectural address |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural address |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Move to the callee window |
| restore_req | input | 1 | Move back to the caller window |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_in | input | NWIN | New mask value |
| cwp | output | clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | Save blocked by the mask |
| unf_trap | output | 1 | Restore blocked by the mask |

## Verification
A wrong pointer does not stay hidden. The next read of a local, in or out register returns data from another window, and the cwp port differs at once. A wrong address map can go unseen until two windows share data. It shows up when a value written to an out is read back through the next window's in after a save, or when a local leaks across a restore. The bench keeps per-window out and local frames and a global bank, and compares both read ports, the pointer and both traps on every cycle. A corrupted mask or a missed trap therefore shows in the cycle the blocked move is requested.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned ARCH_W  = 5;
  localparam int unsigned NGLOB   = 8;
  localparam int unsigned WIN_SPAN = 16;

  // Map architectural register r in window w onto a physical slot.
  function automatic int unsigned wrf_phys(int unsigned w, int unsigned r,
                                           int unsigned nwin);
    if (r < NGLOB) return r;
    return NGLOB + ((w * WIN_SPAN + (r - NGLOB)) % (WIN_SPAN * nwin));
  endfunction

  function automatic int unsigned wrf_down(int unsigned w, int unsigned nwin);
    return (w == 0) ? nwin - 1 : w - 1;
  endfunction

  function automatic int unsigned wrf_up(int unsigned w, int unsigned nwin);
    return (w == nwin - 1) ? 0 : w + 1;
  endfunction
endpackage

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_in,
  output logic [CW-1:0]   cwp,
  output logic            ovf_trap,
  output logic            unf_trap
);
  import wrf_pkg::*;

  logic [NWIN-1:0] mask_q;
  logic [CW-1:0]   cwp_dn, cwp_up;
  logic            do_save, do_restore, save_ok, restore_ok;

  assign cwp_dn     = CW'(wrf_down(int'(cwp), NWIN));
  assign cwp_up     = CW'(wrf_up(int'(cwp), NWIN));
  assign do_save    = save_req;
  assign do_restore = restore_req && !save_req;
  assign ovf_trap   = do_save && mask_q[cwp_dn];
  assign unf_trap   = do_restore && mask_q[cwp_up];
  assign save_ok    = do_save && !ovf_trap;
  assign restore_ok = do_restore && !unf_trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp    <= '0;
      mask_q <= NWIN'(2);
    end else begin
      if (save_ok)         cwp <= cwp_dn;
      else if (restore_ok) cwp <= cwp_up;
      if (mask_we) mask_q <= mask_in;
    end
  end

  p_save_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    save_ok |=> (cwp == (($past(cwp) == 0) ? CW'(NWIN - 1) : $past(cwp) - 1'b1)));
  p_hold_on_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> $stable(cwp));
  p_hold_on_unf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |=> $stable(cwp));
  p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_in)));
  p_one_trap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap, unf_trap}));
endmodule

// File: rtl/wrf_map.sv
module wrf_map #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW = $clog2(NWIN),
  localparam int unsigned PW = $clog2(8 + 16 * NWIN)
) (
  input  logic [CW-1:0] cwp,
  input  logic [4:0]    arch,
  output logic [PW-1:0] phys
);
  import wrf_pkg::*;
  assign phys = PW'(wrf_phys(int'(cwp), int'(arch), NWIN));
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned NPHYS = 136,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned PW = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   ra_idx,
  input  logic [PW-1:0]   rb_idx,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data
);
  logic [XLEN-1:0] mem [NPHYS];
  logic wr_go, a_hit, b_hit;

  assign wr_go = wr_en && (wr_idx != '0);
  assign a_hit = wr_go && (ra_idx == wr_idx);
  assign b_hit = wr_go && (rb_idx == wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NPHYS); i++) mem[i] <= '0;
    end else if (wr_go) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    if (ra_idx == '0)  ra_data = '0;
    else if (a_hit)    ra_data = wr_data;
    else               ra_data = mem[ra_idx];
    if (rb_idx == '0)  rb_data = '0;
    else if (b_hit)    rb_data = wr_data;
    else               rb_data = mem[rb_idx];
  end

  p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == '0) |-> (ra_data == '0));
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (mem[$past(wr_idx)] == $past(wr_data)));
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rb_idx == wr_idx) |-> (rb_data == wr_data));
endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW = $clog2(NWIN),
  localparam int unsigned NPHYS = 8 + 16 * NWIN,
  localparam int unsigned PW = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [4:0]      rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_in,
  output logic [CW-1:0]   cwp,
  output logic            ovf_trap,
  output logic            unf_trap
);
  logic [4:0]    arch [3];
  logic [PW-1:0] phys [3];

  assign arch[0] = ra_addr;
  assign arch[1] = rb_addr;
  assign arch[2] = wr_addr;

  wrf_window_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .mask_we(mask_we), .mask_in(mask_in), .cwp(cwp),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  for (genvar p = 0; p < 3; p++) begin : g_port_map
    wrf_map #(.NWIN(NWIN)) u_map (.cwp(cwp), .arch(arch[p]), .phys(phys[p]));
  end

  wrf_storage #(.NPHYS(NPHYS), .XLEN(XLEN)) u_store (
    .clk(clk), .rst_n(rst_n), .ra_idx(phys[0]), .rb_idx(phys[1]),
    .wr_en(wr_en), .wr_idx(phys[2]), .wr_data(wr_data),
    .ra_data(ra_data), .rb_data(rb_data)
  );
endmodule

// File: tb/test_wreg_file.sv
module test_wreg_file;
  localparam int N = 8;
  localparam int CW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [4:0] ra_addr = 0, rb_addr = 0, wr_addr = 0;
  logic [31:0] ra_data, rb_data, wr_data = 0;
  logic wr_en = 0, save_req = 0, restore_req = 0, mask_we = 0;
  logic [N-1:0] mask_in = 0;
  logic [CW-1:0] cwp;
  logic ovf_trap, unf_trap;

  always #10 clk = ~clk;

  wreg_file #(.NWIN(N)) i_wreg_file (.*);

  // Behavioural model: a global bank plus per-window out and local frames.
  logic [31:0] glob [8];
  logic [31:0] outs [N][8];
  logic [31:0] locs [N][8];
  int m_cwp;
  logic [N-1:0] m_mask;
  int total = 0, bad = 0;
  string tag = "R4";
  bit done = 0;

  function automatic logic [31:0] mread(int r);
    if (r == 0) return 0;
    if (r < 8) return glob[r];
    if (r < 16) return outs[m_cwp][r-8];
    if (r < 24) return locs[m_cwp][r-16];
    return outs[(m_cwp + 1) % N][r-24];
  endfunction

  task automatic mwrite(int r, logic [31:0] d);
    if (r == 0) return;
    if (r < 8) glob[r] = d;
    else if (r < 16) outs[m_cwp][r-8] = d;
    else if (r < 24) locs[m_cwp][r-16] = d;
    else outs[(m_cwp + 1) % N][r-24] = d;
  endtask

  task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cyc(bit sv, bit rs, bit mwe, logic [N-1:0] mi, bit we,
                     int wa, logic [31:0] wd, int ra, int rb);
    logic [31:0] ea, eb;
    bit eo, eu;
    int tgt;
    @(negedge clk);
    save_req = sv; restore_req = rs; mask_we = mwe; mask_in = mi;
    wr_en = we; wr_addr = 5'(wa); wr_data = wd; ra_addr = 5'(ra); rb_addr = 5'(rb);
    #3;
    ea = (we && wa != 0 && ra == wa) ? wd : mread(ra);
    eb = (we && wa != 0 && rb == wa) ? wd : mread(rb);
    eo = sv && m_mask[(m_cwp + N - 1) % N];
    eu = !sv && rs && m_mask[(m_cwp + 1) % N];
    chk(ra_data == ea, {tag, " port A"}, ra_data, ea);
    chk(rb_data == eb, {tag, " port B"}, rb_data, eb);
    chk(int'(cwp) == m_cwp, "R6 pointer", 32'(cwp), 32'(m_cwp));
    chk(ovf_trap == eo, "R9 overflow", 32'(ovf_trap), 32'(eo));
    chk(unf_trap == eu, "R10 underflow", 32'(unf_trap), 32'(eu));
    @(posedge clk);
    if (we) mwrite(wa, wd);
    if (sv) begin
      tgt = (m_cwp + N - 1) % N;
      if (!m_mask[tgt]) m_cwp = tgt;          // R12: save wins
    end else if (rs) begin
      tgt = (m_cwp + 1) % N;
      if (!m_mask[tgt]) m_cwp = tgt;
    end
    if (mwe) m_mask = mi;                     // R11
  endtask

  task automatic rd(int ra, int rb);
    cyc(0, 0, 0, 0, 0, 0, 0, ra, rb);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) glob[i] = 0;
    for (int w = 0; w < N; w++)
      for (int i = 0; i < 8; i++) begin outs[w][i] = 0; locs[w][i] = 0; end
    m_cwp = 0; m_mask = N'(2);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    tag = "R1";
    for (int r = 0; r < 32; r += 2) rd(r, r + 1);
    cyc(0, 1, 0, 0, 0, 0, 0, 9, 25);          // R1/R10: reset mask blocks window 1
    // R2: register 0
    tag = "R2";
    cyc(0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0);
    rd(0, 0);
    // R4: write then read both ports
    tag = "R4";
    cyc(0, 0, 0, 0, 1, 17, 32'h0000_0AAA, 17, 3);
    cyc(0, 0, 0, 0, 1, 8, 32'h0000_0011, 17, 8);
    cyc(0, 0, 0, 0, 1, 3, 32'h3333_0003, 8, 17);
    // R5: same-cycle bypass on both ports
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 20, 32'h5555_AAAA, 20, 20);
    // R7: caller outs become callee ins after a save
    tag = "R7";
    cyc(1, 0, 0, 0, 0, 0, 0, 24, 8);
    rd(24, 8);
    // R3: globals seen from the callee window
    tag = "R3";
    rd(3, 0);
    // R8: locals private per window
    tag = "R8";
    cyc(0, 0, 0, 0, 1, 17, 32'h7777_0017, 17, 20);
    cyc(0, 1, 0, 0, 0, 0, 0, 17, 20);
    rd(17, 20);
    // R11: load a mask, trap decided with old mask this cycle
    tag = "R11";
    cyc(0, 0, 1, N'(1) << (N - 1), 0, 0, 0, 1, 2);
    cyc(1, 0, 0, 0, 0, 0, 0, 3, 8);           // R9 overflow into window N-1
    // R6: wrap both ways with an empty mask
    tag = "R6";
    cyc(0, 0, 1, '0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 24, 8);
    cyc(0, 1, 0, 0, 0, 0, 0, 24, 8);
    for (int i = 0; i < N; i++) cyc(0, 1, 0, 0, 1, 8 + i, 32'(i + 100), 24, 8);
    // R12: both requests, save wins
    tag = "R12";
    cyc(1, 1, 0, 0, 0, 0, 0, 24, 9);
    cyc(1, 1, 1, N'(1) << ((m_cwp + N - 1) % N), 0, 0, 0, 9, 25);
    cyc(1, 1, 0, 0, 0, 0, 0, 9, 25);
    // Mixed traffic
    tag = "R4 mix";
    for (int k = 0; k < 3000; k++) begin
      int p = $urandom_range(0, 99);
      cyc(p < 8, p >= 6 && p < 14, p >= 97, N'($urandom),
          $urandom_range(0, 3) != 0, $urandom_range(0, 31), $urandom,
          $urandom_range(0, 31), $urandom_range(0, 31));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule